// File: doc/BRIEF.md
# Set/Clear GPIO Flag Controller

This block serves sixteen general-purpose flag pins, each one an input or an output. Software reaches it over a small register bus with one write port and a combinational read port. The output values and the interrupt enables are never written directly. Each has a register that sets bits wherever the written word holds a one and a second register that clears them. Software can therefore change single pins without a read-modify-write sequence.

Every pin is an interrupt source. An input pin goes through a synchronizer, and its level is the source. An output pin uses its own driven value as the source, so software can raise an interrupt by writing to it. For each pin, software chooses the active polarity, level or edge detection, and for edge detection whether rising only or both edges count. Edges are held in sticky event bits that are cleared by writing ones. The single interrupt output is the OR of every enabled and active pin.

A static bus-mode input hands the upper half of the pins to an external data bus. While it is high, those pins are neither driven nor sampled by the flag logic.

Top module: `gpio_flag_ctrl`

## Requirements
- R1: After reset the direction, output value, enable, polarity, sensitivity, both-edge and event registers read zero, `pin_oe_o` is zero and `irq_o` is low.
- R2: `pin_oe_o` equals the direction register (address 0, bit 1 = output) and `pin_o` equals the output value register, for each pin that the bus mode has not taken over.
- R3: A write to address 2 sets the output value bits where the write data holds ones, and a write to address 3 clears them. Zero bits leave the value unchanged, and both addresses read back the current output value.
- R4: Address 1 reads the output value for output pins and the synchronized pin level for input pins. An input change is first visible on the second rising clock edge after it, not on the first.
- R5: A write to address 4 sets interrupt enable bits and a write to address 5 clears them, where the write data holds ones. Both addresses read back the current enables.
- R6: With a pin in level mode (address 7, bit 0), the pin is active while its source differs from its polarity bit (address 6, bit 1 = active low). `irq_o` is high exactly when some enabled pin is active.
- R7: In edge mode (address 7, bit 1) with address 8 bit 0, only a transition of the source toward the active polarity sets that pin's event bit (address 9). The event bit is latched within three clock edges for an input pin, and an edge-mode pin is active while its event bit is set.
- R8: In edge mode with address 8 bit 1, both transitions of the source set the event bit.
- R9: An output pin is an interrupt source driven by its own output value. In level mode it acts on `irq_o` in the cycle after the write. In edge mode its event bit is set one clock after the write that changed it.
- R10: While `bus16_i` is high, pins 15 to 8 have `pin_oe_o` and `pin_o` at zero. They read zero at address 1, never drive `irq_o` and latch no new events.
- R11: Writing to address 9 clears the event bits where the write data holds ones and leaves the others set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| bus16_i | input | 1 | Upper pins taken over as data lines |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Values to drive on the pads |
| pin_oe_o | output | 16 | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are edges on a pin whose polarity is inverted, or whose direction is output. Output pins are hard because their source is a register and not the pad. The stimulus first brings every input pin to a settled level and clears the events, and only then changes polarity. It then produces each edge by toggling the pad, or by writing to the set or clear register for the output value. The events are read back at fixed cycle offsets after each edge, and the reads show both which transitions are latched and which are ignored.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 4'd0,
    REG_DATA = 4'd1,
    REG_DSET = 4'd2,
    REG_DCLR = 4'd3,
    REG_MSET = 4'd4,
    REG_MCLR = 4'd5,
    REG_POL  = 4'd6,
    REG_SENS = 4'd7,
    REG_BOTH = 4'd8,
    REG_EVT  = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_flag_sc_reg.sv
module gpio_flag_sc_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/gpio_flag_regs.sv
module gpio_flag_regs
  import gpio_flag_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      level_i,
  input  logic [N-1:0]      evt_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      out_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      sens_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      evt_clr_o
);
  logic [N-1:0] dset, dclr, mset, mclr;

  function automatic logic [N-1:0] strobe(input logic hit, input logic [N-1:0] d);
    return hit ? d : '0;
  endfunction

  assign dset      = strobe(we_i && addr_i == REG_DSET, wdata_i);
  assign dclr      = strobe(we_i && addr_i == REG_DCLR, wdata_i);
  assign mset      = strobe(we_i && addr_i == REG_MSET, wdata_i);
  assign mclr      = strobe(we_i && addr_i == REG_MCLR, wdata_i);
  assign evt_clr_o = strobe(we_i && addr_i == REG_EVT,  wdata_i);

  gpio_flag_sc_reg #(.N(N)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(dset), .clr_i(dclr), .q_o(out_o)
  );

  gpio_flag_sc_reg #(.N(N)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(mset), .clr_i(mclr), .q_o(mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      pol_o  <= '0;
      sens_o <= '0;
      both_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_DIR:  dir_o  <= wdata_i;
        REG_POL:  pol_o  <= wdata_i;
        REG_SENS: sens_o <= wdata_i;
        REG_BOTH: both_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      REG_DIR:            rdata_o = dir_o;
      REG_DATA:           rdata_o = level_i;
      REG_DSET, REG_DCLR: rdata_o = out_o;
      REG_MSET, REG_MCLR: rdata_o = mask_o;
      REG_POL:            rdata_o = pol_o;
      REG_SENS:           rdata_o = sens_o;
      REG_BOTH:           rdata_o = both_o;
      REG_EVT:            rdata_o = evt_i;
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_flag_sync.sv
module gpio_flag_sync #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_flag_irq.sv
module gpio_flag_irq #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] sens_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] taken_i,
  input  logic [N-1:0] evt_clr_i,
  output logic [N-1:0] evt_o,
  output logic         irq_o
);
  logic [N-1:0] active;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic prev_q, evt_q, edge_hit;

    // edge toward active polarity, or any change in both-edge mode
    always_comb begin
      if (both_i[g])     edge_hit = prev_q ^ src_i[g];
      else if (pol_i[g]) edge_hit = prev_q & ~src_i[g];
      else               edge_hit = ~prev_q & src_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        evt_q  <= 1'b0;
      end else begin
        prev_q <= src_i[g];
        // a fresh edge outranks a clear in the same cycle
        evt_q  <= (evt_q & ~evt_clr_i[g]) | (edge_hit & sens_i[g] & ~taken_i[g]);
      end
    end

    assign active[g] = ~taken_i[g] & (sens_i[g] ? evt_q : (src_i[g] ^ pol_i[g]));
    assign evt_o[g]  = evt_q;
  end

  assign irq_o = |(active & mask_i);
endmodule

// File: rtl/gpio_flag_ctrl.sv
module gpio_flag_ctrl
  import gpio_flag_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned SHARED_PINS = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic                bus16_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam logic [NUM_PINS-1:0] SHARED_MASK =
    ~({NUM_PINS{1'b1}} >> SHARED_PINS);

  logic [NUM_PINS-1:0] dir_q, out_q, mask_q, pol_q, sens_q, both_q;
  logic [NUM_PINS-1:0] evt_q, evt_clr, sync_q, src, taken, level;

  assign taken = bus16_i ? SHARED_MASK : '0;

  gpio_flag_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_q)
  );

  assign src   = (dir_q & out_q) | (~dir_q & sync_q);
  assign level = src & ~taken;

  gpio_flag_regs #(.N(NUM_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .level_i(level), .evt_i(evt_q), .rdata_o(rdata_o),
    .dir_o(dir_q), .out_o(out_q), .mask_o(mask_q), .pol_o(pol_q),
    .sens_o(sens_q), .both_o(both_q), .evt_clr_o(evt_clr)
  );

  gpio_flag_irq #(.N(NUM_PINS)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src), .pol_i(pol_q),
    .sens_i(sens_q), .both_i(both_q), .mask_i(mask_q), .taken_i(taken),
    .evt_clr_i(evt_clr), .evt_o(evt_q), .irq_o(irq_o)
  );

  assign pin_oe_o = dir_q & ~taken;
  assign pin_o    = out_q & ~taken;
endmodule

// File: rtl/gpio_flag_chk.sv
module gpio_flag_chk
  import gpio_flag_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned SHARED_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] out_q,
  input logic [NUM_PINS-1:0] mask_q,
  input logic [NUM_PINS-1:0] sens_q,
  input logic [NUM_PINS-1:0] evt_q,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                bus16_i,
  input logic                irq_o
);
  localparam logic [NUM_PINS-1:0] UPPER = ~({NUM_PINS{1'b1}} >> SHARED_PINS);

  // R3
  dset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DSET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));

  // R3
  dclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_DCLR) |=> ((out_q & $past(wdata_i)) == '0));

  // R5
  mset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_MSET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  // R5
  mclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_MCLR) |=> ((mask_q & $past(wdata_i)) == '0));

  // R6
  irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));

  // R10
  shared_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus16_i |-> ((pin_oe_o & UPPER) == '0));

  // R7
  evt_only_edge_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(sens_q)) == '0));
endmodule

bind gpio_flag_ctrl gpio_flag_chk #(.NUM_PINS(NUM_PINS), .SHARED_PINS(SHARED_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .out_q(out_q), .mask_q(mask_q), .sens_q(sens_q), .evt_q(evt_q),
  .pin_oe_o(pin_oe_o), .bus16_i(bus16_i), .irq_o(irq_o)
);

// File: tb/gpio_flag_ctrl_test.sv
`timescale 1ns/1ps
module gpio_flag_ctrl_test;
  localparam logic [3:0] A_DIR = 4'd0, A_DATA = 4'd1, A_DSET = 4'd2, A_DCLR = 4'd3,
                         A_MSET = 4'd4, A_MCLR = 4'd5, A_POL = 4'd6, A_SENS = 4'd7,
                         A_BOTH = 4'd8, A_EVT = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        bus16 = 1'b0;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio_flag_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .bus16_i(bus16), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] patt(input int i);
    return 16'(i * 40503) ^ 16'(i << 3) ^ 16'h5a3c;
  endfunction

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r, m_out, m_mask, v, prev_pin;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);

    // R1 reset state
    foreach (r[k]) begin end
    rd(A_DIR, r);  chk("R1 dir", r, 16'h0);
    rd(A_DSET, r); chk("R1 out", r, 16'h0);
    rd(A_MSET, r); chk("R1 mask", r, 16'h0);
    rd(A_POL, r);  chk("R1 pol", r, 16'h0);
    rd(A_SENS, r); chk("R1 sens", r, 16'h0);
    rd(A_BOTH, r); chk("R1 both", r, 16'h0);
    rd(A_EVT, r);  chk("R1 evt", r, 16'h0);
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R3 output value set/clear sweep
    m_out = '0;
    for (int i = 0; i < 12; i++) begin
      v = patt(i);
      if (i % 2 == 0) begin wr(A_DSET, v); m_out |= v; end
      else            begin wr(A_DCLR, v); m_out &= ~v; end
      rd(A_DSET, r); chk("R3 dset read", r, m_out);
      rd(A_DCLR, r); chk("R3 dclr read", r, m_out);
      chk("R2 pin_o", pin_out, m_out);
    end

    // R2 direction drives output enables
    for (int i = 0; i < 8; i++) begin
      v = patt(i + 20);
      wr(A_DIR, v);
      chk("R2 oe", pin_oe, v);
      rd(A_DIR, r); chk("R2 dir read", r, v);
    end

    // R4 data read and two-edge synchronizer latency
    wr(A_DIR, 16'h00ff);
    prev_pin = 16'h0;
    for (int i = 0; i < 6; i++) begin
      v = patt(i + 40);
      pin_in = v;
      ticks(1);
      rd(A_DATA, r); chk("R4 data after one edge", r, (m_out & 16'h00ff) | (prev_pin & 16'hff00));
      ticks(1);
      rd(A_DATA, r); chk("R4 data after two edges", r, (m_out & 16'h00ff) | (v & 16'hff00));
      prev_pin = v;
    end

    // R5 interrupt enable set/clear sweep
    m_mask = '0;
    for (int i = 0; i < 10; i++) begin
      v = patt(i + 60);
      if (i % 3 != 2) begin wr(A_MSET, v); m_mask |= v; end
      else            begin wr(A_MCLR, v); m_mask &= ~v; end
      rd(A_MSET, r); chk("R5 mset read", r, m_mask);
      rd(A_MCLR, r); chk("R5 mclr read", r, m_mask);
    end
    wr(A_MCLR, 16'hffff);

    // R6 level mode, active high then active low
    wr(A_DIR, 16'h0); wr(A_POL, 16'h0); wr(A_SENS, 16'h0);
    pin_in = 16'h0;
    wr(A_MSET, 16'hffff);
    ticks(2);
    chk("R6 idle irq", {15'h0, irq}, 16'h0);
    for (int i = 0; i < 16; i++) begin
      pin_in = 16'h1 << i; ticks(2);
      chk("R6 level high irq", {15'h0, irq}, 16'h1);
      pin_in = 16'h0; ticks(2);
      chk("R6 level low irq", {15'h0, irq}, 16'h0);
    end
    wr(A_POL, 16'hffff);
    pin_in = 16'hffff; ticks(2);
    chk("R6 active-low idle", {15'h0, irq}, 16'h0);
    for (int i = 0; i < 16; i++) begin
      pin_in = ~(16'h1 << i); ticks(2);
      chk("R6 active-low irq", {15'h0, irq}, 16'h1);
      pin_in = 16'hffff; ticks(2);
      chk("R6 active-low release", {15'h0, irq}, 16'h0);
    end
    wr(A_MCLR, 16'hffff); wr(A_MSET, 16'h0008);
    pin_in = ~16'h0020; ticks(2);
    chk("R6 disabled pin no irq", {15'h0, irq}, 16'h0);
    pin_in = ~16'h0008; ticks(2);
    chk("R6 enabled pin irq", {15'h0, irq}, 16'h1);
    pin_in = 16'h0; ticks(2);
    wr(A_POL, 16'h0); wr(A_MCLR, 16'hffff);

    // R7 rising-only edge events
    wr(A_SENS, 16'hffff); wr(A_BOTH, 16'h0);
    ticks(3);
    wr(A_EVT, 16'hffff);
    rd(A_EVT, r); chk("R7 evt cleared", r, 16'h0);
    for (int i = 0; i < 16; i++) begin
      pin_in = 16'h1 << i; ticks(4);
      rd(A_EVT, r); chk("R7 rising latched", r, 16'h1 << i);
      pin_in = 16'h0; ticks(4);
      rd(A_EVT, r); chk("R7 falling ignored", r, 16'h1 << i);
      wr(A_EVT, 16'h1 << i);
      rd(A_EVT, r); chk("R11 single clear", r, 16'h0);
    end
    wr(A_POL, 16'hffff);
    pin_in = 16'hffff; ticks(4);
    rd(A_EVT, r); chk("R7 active-low rise ignored", r, 16'h0);
    for (int i = 0; i < 16; i += 3) begin
      pin_in = ~(16'h1 << i); ticks(4);
      rd(A_EVT, r); chk("R7 active-low fall latched", r, 16'h1 << i);
      pin_in = 16'hffff; ticks(4);
      wr(A_EVT, 16'hffff);
    end
    wr(A_POL, 16'h0);
    pin_in = 16'h0; ticks(4);
    rd(A_EVT, r); chk("R7 falling ignored after pol change", r, 16'h0);

    // R8 both edges
    wr(A_BOTH, 16'hffff);
    for (int i = 0; i < 16; i++) begin
      pin_in = 16'h1 << i; ticks(4);
      rd(A_EVT, r); chk("R8 rise latched", r, 16'h1 << i);
      wr(A_EVT, 16'hffff);
      pin_in = 16'h0; ticks(4);
      rd(A_EVT, r); chk("R8 fall latched", r, 16'h1 << i);
      wr(A_EVT, 16'hffff);
    end

    // R11 partial clear, events drive irq
    pin_in = 16'h0f0f; ticks(4);
    rd(A_EVT, r); chk("R11 events set", r, 16'h0f0f);
    wr(A_EVT, 16'h0303);
    rd(A_EVT, r); chk("R11 partial clear", r, 16'h0c0c);
    chk("R7 masked event no irq", {15'h0, irq}, 16'h0);
    wr(A_MSET, 16'h0400);
    chk("R7 event irq", {15'h0, irq}, 16'h1);
    wr(A_EVT, 16'h0c0c);
    rd(A_EVT, r); chk("R11 rest cleared", r, 16'h0);
    chk("R7 irq after clear", {15'h0, irq}, 16'h0);
    wr(A_MCLR, 16'hffff);
    pin_in = 16'h0; ticks(4);
    wr(A_EVT, 16'hffff);

    // R9 output pins as software interrupt sources
    wr(A_SENS, 16'h0); wr(A_BOTH, 16'h0);
    wr(A_DCLR, 16'hffff); wr(A_DIR, 16'hffff);
    wr(A_MSET, 16'hffff);
    ticks(1);
    chk("R9 idle", {15'h0, irq}, 16'h0);
    for (int i = 0; i < 16; i++) begin
      wr(A_DSET, 16'h1 << i);
      chk("R9 level sw irq", {15'h0, irq}, 16'h1);
      wr(A_DCLR, 16'h1 << i);
      chk("R9 level sw release", {15'h0, irq}, 16'h0);
    end
    wr(A_MCLR, 16'hffff);
    wr(A_SENS, 16'hffff);
    wr(A_EVT, 16'hffff);
    wr(A_DSET, 16'h0081);
    ticks(1);
    rd(A_EVT, r); chk("R9 edge sw event", r, 16'h0081);
    wr(A_MSET, 16'h0080);
    chk("R9 edge sw irq", {15'h0, irq}, 16'h1);
    wr(A_MCLR, 16'hffff);
    wr(A_EVT, 16'hffff);

    // R10 upper pins taken over by the data bus
    wr(A_SENS, 16'h0);
    bus16 = 1'b1;
    wr(A_DSET, 16'hffff);
    chk("R10 oe upper off", pin_oe, 16'h00ff);
    chk("R10 pin_o upper off", pin_out, 16'h00ff);
    rd(A_DATA, r); chk("R10 data upper zero", r, 16'h00ff);
    wr(A_MSET, 16'hff00);
    chk("R10 upper no irq", {15'h0, irq}, 16'h0);
    wr(A_MSET, 16'h0001);
    chk("R10 lower irq", {15'h0, irq}, 16'h1);
    wr(A_MCLR, 16'hffff);
    wr(A_SENS, 16'hffff); wr(A_BOTH, 16'hffff);
    wr(A_EVT, 16'hffff);
    wr(A_DCLR, 16'hff00); ticks(2);
    rd(A_EVT, r); chk("R10 upper no event", r, 16'h0);
    wr(A_DCLR, 16'h0001); ticks(2);
    rd(A_EVT, r); chk("R10 lower event", r, 16'h0001);
    bus16 = 1'b0;
    #1;
    chk("R2 oe restored", pin_oe, 16'hffff);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule